// File: doc/BRIEF.md
# Operand-Gated In-Order Decode and Issue Front End

This block is the front end of a small core that knows four operations: add, subtract, multiply and store. Instructions are loaded in program order into a 16-entry instruction store. On each step the oldest instruction is examined. It is decoded only when the registers it reads hold valid values. Decoding replaces the register names with those values and gives the record a sequence tag. The decoded record then goes into one of two queues. Arithmetic records go to an arithmetic queue and store records go to a store queue. Each queue has its own consumer handshake.

The register file lives outside the block. The block drives two read addresses from the oldest instruction and gets back a valid bit and a value on each port, in the same cycle. Progress happens only on cycles where `step_en` is high. On each step the decode stage and the two issue stages each fire at most once, and each uses only what its input held at the start of the step.

A per-class staging slot sits between decode and each queue. Each slot is a two-state machine. In SLOT_EMPTY, a decode of its class moves it to SLOT_HELD. In SLOT_HELD, an issue on a step whose queue is not full returns it to SLOT_EMPTY, unless a new decode refills it in the same step, in which case it stays in SLOT_HELD.

The decode stage classifies the oldest instruction every cycle with one of four verdicts:
- DV_IDLE: there is no instruction.
- DV_WAIT_OPND: a needed source register is not valid.
- DV_WAIT_SLOT: the slot of its class is busy and will not drain this step.
- DV_FIRE: the instruction decodes on this step if `step_en` is high.

Top module: `idi_front`

## Requirements
- R1: While reset is active, and directly after it, both queues and the instruction store are empty. `aq_valid`, `sq_valid`, `ld_full`, `aq_full` and `sq_full` are all low.
- R2: The instruction store holds 16 instructions. `ld_full` is high when it holds 16. A load offered while `ld_full` is high is not taken.
- R3: Decode always takes the oldest instruction. Sequence tags start at 0 after reset and rise by one per decoded instruction, modulo 2^SEQ_W. Each queue delivers its records in program order, and no record is lost or duplicated.
- R4: An add, subtract or multiply decodes only when both of its source registers are valid. A store needs only its first source register to be valid. The low bits of a store's immediate are never used as a register whose validity gates decode.
- R5: A decoded record carries the first source register's value as operand A. Operand B is the second source register's value for arithmetic, or the immediate unchanged for a store. The destination register name is passed on unchanged.
- R6: The opcode encoding is 0 for ADD, 1 for SUB, 2 for MUL and 3 for ST. Records with code 3 go only to the store queue. All other records go only to the arithmetic queue, together with their opcode.
- R7: Nothing decodes or issues on a cycle with `step_en` low. At most one record enters each queue per step.
- R8: With an empty pipeline, a record decoded on one step becomes visible at its queue head after the next step. This is two steps after its operands are valid.
- R9: Each queue holds 16 records and raises its full flag when it holds 16. A full queue holds back its issue stage without dropping the waiting record.
- R10: While an arithmetic record sits in its slot behind a full arithmetic queue, a store record that follows it in program order still decodes and enters the store queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance one step on this cycle |
| ld_valid | input | 1 | Instruction offered for loading |
| ld_op | input | 2 | Opcode of the offered instruction |
| ld_dst | input | REG_AW | Destination register |
| ld_src1 | input | REG_AW | First source register |
| ld_src2 | input | DATA_W | Second source register (low bits) or store immediate |
| ld_full | output | 1 | Instruction store full |
| rf_raddr_a | output | REG_AW | Register file read address for the first source |
| rf_raddr_b | output | REG_AW | Register file read address for the second source |
| rf_rvalid_a | input | 1 | Valid bit of register at rf_raddr_a |
| rf_rdata_a | input | DATA_W | Value of register at rf_raddr_a |
| rf_rvalid_b | input | 1 | Valid bit of register at rf_raddr_b |
| rf_rdata_b | input | DATA_W | Value of register at rf_raddr_b |
| aq_valid | output | 1 | Arithmetic queue head valid |
| aq_ready | input | 1 | Consumer takes the arithmetic head |
| aq_op | output | 2 | Head opcode |
| aq_dst | output | REG_AW | Head destination register |
| aq_opa | output | DATA_W | Head operand A |
| aq_opb | output | DATA_W | Head operand B |
| aq_seq | output | SEQ_W | Head sequence tag |
| aq_full | output | 1 | Arithmetic queue full |
| sq_valid | output | 1 | Store queue head valid |
| sq_ready | input | 1 | Consumer takes the store head |
| sq_data_reg | output | REG_AW | Register whose value is to be stored |
| sq_base | output | DATA_W | Base register value |
| sq_offset | output | DATA_W | Immediate offset |
| sq_seq | output | SEQ_W | Head sequence tag |
| sq_full | output | 1 | Store queue full |

## Verification
The hardest state to reach is the one behind R10. It needs a full arithmetic queue, one more arithmetic record parked in its staging slot, and a store directly behind that record in the instruction store. The stimulus sets this up directly. It first holds `step_en` low and loads 16 arithmetic instructions until `ld_full` rises. It then keeps the arithmetic consumer stalled while stepping, loads one further arithmetic instruction followed by a store, and watches the store appear while `aq_full` stays high. Operand gating is driven by a register-file model whose valid bits only ever turn on, at random times. Invalid registers return a poison value, so any decode that ignores a valid bit shows up as a wrong operand.

// File: rtl/idi_pkg.sv
`timescale 1ns/1ps
package idi_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_ST  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_WAIT_OPND,
        DV_WAIT_SLOT,
        DV_FIRE
    } dec_verdict_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/idi_fifo.sv
`timescale 1ns/1ps
module idi_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    assign rdata = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/idi_decode.sv
`timescale 1ns/1ps
module idi_decode
    import idi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4
) (
    input  logic              step_en,
    input  logic              head_vld,
    input  op_e               head_op,
    input  logic [REG_AW-1:0] head_src1,
    input  logic [DATA_W-1:0] head_src2,
    output logic [REG_AW-1:0] raddr_a,
    output logic [REG_AW-1:0] raddr_b,
    input  logic              rvalid_a,
    input  logic [DATA_W-1:0] rdata_a,
    input  logic              rvalid_b,
    input  logic [DATA_W-1:0] rdata_b,
    input  logic              arith_free,
    input  logic              store_free,
    output logic              fire,
    output logic              to_store,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);
    dec_verdict_e verdict;
    logic         opnd_ok, slot_ok;

    assign raddr_a  = head_src1;
    assign raddr_b  = head_src2[REG_AW-1:0];
    assign to_store = (head_op == OP_ST);

    always_comb begin
        opnd_ok = rvalid_a && (to_store || rvalid_b);
        slot_ok = to_store ? store_free : arith_free;
        if (!head_vld)     verdict = DV_IDLE;
        else if (!opnd_ok) verdict = DV_WAIT_OPND;
        else if (!slot_ok) verdict = DV_WAIT_SLOT;
        else               verdict = DV_FIRE;
    end

    always_comb begin
        fire = 1'b0;
        unique case (verdict)
            DV_FIRE:                               fire = step_en;
            DV_IDLE, DV_WAIT_OPND, DV_WAIT_SLOT:   fire = 1'b0;
        endcase
    end

    always_comb begin
        opa = rdata_a;
        opb = to_store ? head_src2 : rdata_b;
    end
endmodule

// File: rtl/idi_issue_slot.sv
`timescale 1ns/1ps
module idi_issue_slot
    import idi_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             q_full,
    output logic             issue,
    output logic [WIDTH-1:0] rec,
    output logic             free
);
    slot_state_e      state, nxt;
    logic [WIDTH-1:0] data_q;

    always_comb begin
        nxt   = state;
        issue = 1'b0;
        unique case (state)
            SLOT_EMPTY: begin
                if (load) nxt = SLOT_HELD;
            end
            SLOT_HELD: begin
                issue = step_en && !q_full;
                if (issue && !load) nxt = SLOT_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (load) data_q <= load_data;
    end

    always_comb begin
        rec  = data_q;
        free = (state == SLOT_EMPTY) || issue;
    end
endmodule

// File: rtl/idi_front.sv
`timescale 1ns/1ps
module idi_front
    import idi_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int REG_AW   = 4,
    parameter int SEQ_W    = 8,
    parameter int IQ_DEPTH = 16,
    parameter int Q_DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              ld_valid,
    input  logic [1:0]        ld_op,
    input  logic [REG_AW-1:0] ld_dst,
    input  logic [REG_AW-1:0] ld_src1,
    input  logic [DATA_W-1:0] ld_src2,
    output logic              ld_full,
    output logic [REG_AW-1:0] rf_raddr_a,
    output logic [REG_AW-1:0] rf_raddr_b,
    input  logic              rf_rvalid_a,
    input  logic [DATA_W-1:0] rf_rdata_a,
    input  logic              rf_rvalid_b,
    input  logic [DATA_W-1:0] rf_rdata_b,
    output logic              aq_valid,
    input  logic              aq_ready,
    output logic [1:0]        aq_op,
    output logic [REG_AW-1:0] aq_dst,
    output logic [DATA_W-1:0] aq_opa,
    output logic [DATA_W-1:0] aq_opb,
    output logic [SEQ_W-1:0]  aq_seq,
    output logic              aq_full,
    output logic              sq_valid,
    input  logic              sq_ready,
    output logic [REG_AW-1:0] sq_data_reg,
    output logic [DATA_W-1:0] sq_base,
    output logic [DATA_W-1:0] sq_offset,
    output logic [SEQ_W-1:0]  sq_seq,
    output logic              sq_full
);
    localparam int RAW_W  = 2 + 2 * REG_AW + DATA_W;
    localparam int SREC_W = SEQ_W + 2 * DATA_W + REG_AW;
    localparam int AREC_W = SREC_W + 2;

    logic [RAW_W-1:0]  iq_rdata;
    logic              iq_empty;
    op_e               head_op;
    logic [REG_AW-1:0] head_dst, head_src1;
    logic [DATA_W-1:0] head_src2;

    logic              dec_fire, dec_to_store;
    logic [DATA_W-1:0] dec_opa, dec_opb;
    logic [SEQ_W-1:0]  seq_q;

    logic              a_free, a_issue;
    logic              s_free, s_issue;
    logic [AREC_W-1:0] a_rec, aq_rdata;
    logic [SREC_W-1:0] s_rec, sq_rdata;
    logic              aq_empty, sq_empty;

    // instruction store, program order
    idi_fifo #(.WIDTH(RAW_W), .DEPTH(IQ_DEPTH)) u_iq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ld_valid),
        .wdata ({ld_src2, ld_src1, ld_dst, ld_op}),
        .pop   (dec_fire),
        .rdata (iq_rdata),
        .empty (iq_empty),
        .full  (ld_full)
    );

    always_comb begin
        head_op   = op_e'(iq_rdata[1:0]);
        head_dst  = iq_rdata[2 +: REG_AW];
        head_src1 = iq_rdata[2 + REG_AW +: REG_AW];
        head_src2 = iq_rdata[2 + 2 * REG_AW +: DATA_W];
    end

    idi_decode #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_dec (
        .step_en    (step_en),
        .head_vld   (!iq_empty),
        .head_op    (head_op),
        .head_src1  (head_src1),
        .head_src2  (head_src2),
        .raddr_a    (rf_raddr_a),
        .raddr_b    (rf_raddr_b),
        .rvalid_a   (rf_rvalid_a),
        .rdata_a    (rf_rdata_a),
        .rvalid_b   (rf_rvalid_b),
        .rdata_b    (rf_rdata_b),
        .arith_free (a_free),
        .store_free (s_free),
        .fire       (dec_fire),
        .to_store   (dec_to_store),
        .opa        (dec_opa),
        .opb        (dec_opb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seq_q <= '0;
        else if (dec_fire) seq_q <= seq_q + 1'b1;
    end

    // arithmetic class: slot then queue
    idi_issue_slot #(.WIDTH(AREC_W)) u_aslot (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .load      (dec_fire && !dec_to_store),
        .load_data ({seq_q, dec_opb, dec_opa, head_dst, head_op}),
        .q_full    (aq_full),
        .issue     (a_issue),
        .rec       (a_rec),
        .free      (a_free)
    );

    idi_fifo #(.WIDTH(AREC_W), .DEPTH(Q_DEPTH)) u_aq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (a_issue),
        .wdata (a_rec),
        .pop   (aq_ready),
        .rdata (aq_rdata),
        .empty (aq_empty),
        .full  (aq_full)
    );

    // store class: slot then queue
    idi_issue_slot #(.WIDTH(SREC_W)) u_sslot (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .load      (dec_fire && dec_to_store),
        .load_data ({seq_q, dec_opb, dec_opa, head_dst}),
        .q_full    (sq_full),
        .issue     (s_issue),
        .rec       (s_rec),
        .free      (s_free)
    );

    idi_fifo #(.WIDTH(SREC_W), .DEPTH(Q_DEPTH)) u_sq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (s_issue),
        .wdata (s_rec),
        .pop   (sq_ready),
        .rdata (sq_rdata),
        .empty (sq_empty),
        .full  (sq_full)
    );

    always_comb begin
        aq_valid    = !aq_empty;
        aq_op       = aq_rdata[1:0];
        aq_dst      = aq_rdata[2 +: REG_AW];
        aq_opa      = aq_rdata[2 + REG_AW +: DATA_W];
        aq_opb      = aq_rdata[2 + REG_AW + DATA_W +: DATA_W];
        aq_seq      = aq_rdata[2 + REG_AW + 2 * DATA_W +: SEQ_W];
        sq_valid    = !sq_empty;
        sq_data_reg = sq_rdata[0 +: REG_AW];
        sq_base     = sq_rdata[REG_AW +: DATA_W];
        sq_offset   = sq_rdata[REG_AW + DATA_W +: DATA_W];
        sq_seq      = sq_rdata[REG_AW + 2 * DATA_W +: SEQ_W];
    end
endmodule

// File: rtl/idi_front_chk.sv
`timescale 1ns/1ps
module idi_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_en,
    input logic       ld_full,
    input logic       aq_valid,
    input logic       aq_ready,
    input logic [1:0] aq_op,
    input logic       aq_full,
    input logic       sq_valid,
    input logic       sq_ready,
    input logic       sq_full
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (!aq_valid && !sq_valid && !ld_full && !aq_full && !sq_full));

    // R6
    arith_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aq_valid |-> (aq_op != 2'd3));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !(aq_valid && aq_ready) && !(sq_valid && sq_ready))
        |=> ($stable(aq_valid) && $stable(sq_valid) && $stable(aq_full) && $stable(sq_full)));

    // R9
    aq_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aq_full && !(aq_valid && aq_ready)) |=> aq_full);

    // R9
    sq_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_full && !(sq_valid && sq_ready)) |=> sq_full);

    // R2
    ld_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_full && !step_en) |=> ld_full);
endmodule

bind idi_front idi_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .ld_full  (ld_full),
    .aq_valid (aq_valid),
    .aq_ready (aq_ready),
    .aq_op    (aq_op),
    .aq_full  (aq_full),
    .sq_valid (sq_valid),
    .sq_ready (sq_ready),
    .sq_full  (sq_full)
);

// File: tb/idi_front_tb_top.sv
`timescale 1ns/1ps
module idi_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_op = '0;
    logic [3:0]  ld_dst = '0, ld_src1 = '0;
    logic [15:0] ld_src2 = '0;
    logic        ld_full;
    logic [3:0]  rf_raddr_a, rf_raddr_b;
    logic        rf_rvalid_a, rf_rvalid_b;
    logic [15:0] rf_rdata_a, rf_rdata_b;
    logic        aq_valid, aq_ready = 1'b0, aq_full;
    logic [1:0]  aq_op;
    logic [3:0]  aq_dst;
    logic [15:0] aq_opa, aq_opb;
    logic [7:0]  aq_seq;
    logic        sq_valid, sq_ready = 1'b0, sq_full;
    logic [3:0]  sq_data_reg;
    logic [15:0] sq_base, sq_offset;
    logic [7:0]  sq_seq;

    logic [15:0] rvld = '0;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  dst;
        logic [15:0] a;
        logic [15:0] b;
        logic [7:0]  seq;
    } exp_t;

    exp_t a_exp[$];
    exp_t s_exp[$];
    int   vectors = 0;
    int   miscomp = 0;
    int   loads = 0;

    always #5 clk = ~clk;

    idi_front dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .ld_valid(ld_valid), .ld_op(ld_op), .ld_dst(ld_dst), .ld_src1(ld_src1),
        .ld_src2(ld_src2), .ld_full(ld_full),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .rf_rvalid_a(rf_rvalid_a), .rf_rdata_a(rf_rdata_a),
        .rf_rvalid_b(rf_rvalid_b), .rf_rdata_b(rf_rdata_b),
        .aq_valid(aq_valid), .aq_ready(aq_ready), .aq_op(aq_op), .aq_dst(aq_dst),
        .aq_opa(aq_opa), .aq_opb(aq_opb), .aq_seq(aq_seq), .aq_full(aq_full),
        .sq_valid(sq_valid), .sq_ready(sq_ready), .sq_data_reg(sq_data_reg),
        .sq_base(sq_base), .sq_offset(sq_offset), .sq_seq(sq_seq), .sq_full(sq_full)
    );

    function automatic logic [15:0] reg_val(input logic [3:0] r);
        return 16'((32'(r) * 37) + 11);
    endfunction

    // register file model: invalid entries return a poison value
    always_comb begin
        rf_rvalid_a = rvld[rf_raddr_a];
        rf_rvalid_b = rvld[rf_raddr_b];
        rf_rdata_a  = rvld[rf_raddr_a] ? reg_val(rf_raddr_a) : 16'hBAD0;
        rf_rdata_b  = rvld[rf_raddr_b] ? reg_val(rf_raddr_b) : 16'hBAD0;
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic exp_t make_exp(input logic [1:0] op, input logic [3:0] d,
                                      input logic [3:0] s1, input logic [15:0] s2);
        exp_t e;
        e.op  = op;
        e.dst = d;
        e.a   = reg_val(s1);
        e.b   = (op == 2'd3) ? s2 : reg_val(s2[3:0]);
        e.seq = 8'(loads);
        return e;
    endfunction

    function automatic void note_load(input logic [1:0] op, input logic [3:0] d,
                                      input logic [3:0] s1, input logic [15:0] s2);
        exp_t e;
        e = make_exp(op, d, s1, s2);
        if (op == 2'd3) s_exp.push_back(e);
        else            a_exp.push_back(e);
        loads++;
    endfunction

    // scoreboard: samples 1 ns before each rising edge
    always begin
        exp_t e;
        @(negedge clk);
        #4;
        if (rst_n) begin
            if (aq_valid && aq_ready) begin
                if (a_exp.size() == 0)
                    check(1'b0, "R3 unexpected arithmetic record", 64'(aq_seq), 64'hFFFF);
                else begin
                    e = a_exp.pop_front();
                    // R3 order/tag, R5 operands, R6 class
                    check({aq_op, aq_dst, aq_opa, aq_opb, aq_seq} == e,
                          "R3/R5/R6 arithmetic record",
                          64'({aq_op, aq_dst, aq_opa, aq_opb, aq_seq}), 64'(e));
                end
            end
            if (sq_valid && sq_ready) begin
                if (s_exp.size() == 0)
                    check(1'b0, "R3 unexpected store record", 64'(sq_seq), 64'hFFFF);
                else begin
                    e = s_exp.pop_front();
                    check({2'd3, sq_data_reg, sq_base, sq_offset, sq_seq} == e,
                          "R3/R5/R6 store record",
                          64'({2'd3, sq_data_reg, sq_base, sq_offset, sq_seq}), 64'(e));
                end
            end
        end
    end

    // called at a negedge, returns at a negedge with ld_valid low
    task automatic put(input logic [1:0] op, input logic [3:0] d,
                       input logic [3:0] s1, input logic [15:0] s2);
        while (ld_full) @(negedge clk);
        ld_valid = 1'b1;
        ld_op = op; ld_dst = d; ld_src1 = s1; ld_src2 = s2;
        note_load(op, d, s1, s2);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic steps(input int n);
        step_en = 1'b1;
        repeat (n) @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic pop_one(input bit store);
        if (store) sq_ready = 1'b1; else aq_ready = 1'b1;
        @(negedge clk);
        sq_ready = 1'b0;
        aq_ready = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    endtask

    initial begin
        #1_500_000;
        miscomp++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!aq_valid && !sq_valid, "R1 queues empty", 64'({aq_valid, sq_valid}), 64'd0);
        check(!ld_full && !aq_full && !sq_full, "R1 full flags low",
              64'({ld_full, aq_full, sq_full}), 64'd0);

        // R4: store gated by first source only; immediate 9 names an invalid register
        rvld = 16'h0002;
        put(2'd3, 4'd5, 4'd1, 16'h0009);
        steps(1);
        check(!sq_valid, "R8 store not yet at head after one step", 64'(sq_valid), 64'd0);
        steps(1);
        check(sq_valid, "R4 store decoded with immediate register invalid", 64'(sq_valid), 64'd1);
        pop_one(1'b1);
        check(!sq_valid, "R3 store queue drained", 64'(sq_valid), 64'd0);

        // R4: arithmetic waits for its second source
        rvld[2] = 1'b1;
        put(2'd0, 4'd1, 4'd2, 16'h0003);
        steps(4);
        check(!aq_valid, "R4 add held while source invalid", 64'(aq_valid), 64'd0);
        rvld[3] = 1'b1;
        steps(1);
        check(!aq_valid, "R8 add one step after operand valid", 64'(aq_valid), 64'd0);
        steps(1);
        check(aq_valid, "R8 add two steps after operand valid", 64'(aq_valid), 64'd1);
        pop_one(1'b0);

        // R2: fill the instruction store with stepping off
        rvld = 16'hFFFF;
        for (int i = 0; i < 16; i++)
            put(2'(i % 3), 4'(i), 4'(i + 1), 16'(i * 5));
        check(ld_full, "R2 instruction store full at 16", 64'(ld_full), 64'd1);
        ld_valid = 1'b1;
        ld_op = 2'd3; ld_dst = 4'd9; ld_src1 = 4'd9; ld_src2 = 16'h0077;
        @(negedge clk);
        ld_valid = 1'b0;
        check(ld_full, "R2 still full after rejected load", 64'(ld_full), 64'd1);
        check(!aq_valid && !sq_valid, "R7 no movement with step_en low",
              64'({aq_valid, sq_valid}), 64'd0);

        // R9: fill the arithmetic queue
        steps(20);
        check(aq_full, "R9 arithmetic queue full at 16", 64'(aq_full), 64'd1);
        check(!ld_full, "R2 store drained by decode", 64'(ld_full), 64'd0);
        // R10: one more add parks in its slot, a store follows it
        put(2'd2, 4'd3, 4'd4, 16'h0005);
        put(2'd3, 4'd7, 4'd4, 16'h0123);
        steps(4);
        check(sq_valid, "R10 store passes blocked arithmetic slot", 64'(sq_valid), 64'd1);
        check(aq_full, "R9 arithmetic queue stays full", 64'(aq_full), 64'd1);
        aq_ready = 1'b1;
        sq_ready = 1'b1;
        steps(25);
        aq_ready = 1'b0;
        sq_ready = 1'b0;
        check(!aq_valid && !sq_valid, "R9 all held records delivered",
              64'({aq_valid, sq_valid}), 64'd0);
        check(a_exp.size() == 0 && s_exp.size() == 0, "R3 no record missing",
              64'(a_exp.size() + s_exp.size()), 64'd0);

        // random phase
        rvld = 16'($urandom) & 16'h5A5A;
        for (int i = 0, n = 0; i < 5000 && n < 220; i++) begin
            step_en  = ($urandom % 4) != 0;
            aq_ready = ($urandom % 5) < 3;
            sq_ready = ($urandom % 5) < 3;
            if (($urandom % 6) == 0) rvld[4'($urandom % 16)] = 1'b1;
            if (!ld_full && (($urandom % 10) < 7)) begin
                ld_op = 2'($urandom % 4); ld_dst = 4'($urandom);
                ld_src1 = 4'($urandom); ld_src2 = 16'($urandom);
                note_load(ld_op, ld_dst, ld_src1, ld_src2);
                ld_valid = 1'b1;
                n++;
            end else begin
                ld_valid = 1'b0;
            end
            @(negedge clk);
        end
        ld_valid = 1'b0;
        rvld = 16'hFFFF;
        step_en = 1'b1;
        aq_ready = 1'b1;
        sq_ready = 1'b1;
        for (int i = 0; i < 400 && (a_exp.size() + s_exp.size()) != 0; i++)
            @(negedge clk);
        step_en = 1'b0;
        @(negedge clk);
        check(a_exp.size() == 0, "R3 random arithmetic stream complete", 64'(a_exp.size()), 64'd0);
        check(s_exp.size() == 0, "R3 random store stream complete", 64'(s_exp.size()), 64'd0);
        check(!aq_valid && !sq_valid, "R7 nothing extra after drain",
              64'({aq_valid, sq_valid}), 64'd0);
        summary();
        $finish;
    end
endmodule